// File: doc/BRIEF.md
# Shared Instruction/Data Scratchpad Memory

This block is a small, tightly coupled on-chip memory that a processor core uses for both instruction fetch and data load/store. It sits after address translation, so every address it sees is physical. To the core it looks like ordinary system memory. Any request whose address falls inside a configurable window is served from one local array. Every other request goes out unchanged on a matching downstream port toward the caches, and that port's acknowledge and read data come straight back.

One single-ported array serves both sides. Instruction fetches have priority and stream at one word per clock. A data load spends one cycle reading the array and one cycle returning the word. A data store completes in the cycle it is presented. Fetches therefore take array bandwidth from the data side. A parameter selects a writable RAM or a read-only array whose contents are computed from the word index.

Top module: `spad_shared`

## Requirements
- R1: A fetch that hits the window reads the array in the cycle it is presented, and its acknowledge and read word appear in the following cycle. The fetch port may present a new address every cycle, giving one word per clock.
- R2: A data load that hits the window, with the array free, reads the array in its first cycle. It is acknowledged with the word in the second cycle, while the request is held, and it does not read the array a second time.
- R3: A data store that hits the window, with no hitting fetch in the same cycle, is acknowledged in that same cycle. Byte select bit k (k = 0..3) enables the write of data bits 8k+7..8k. Unselected bytes keep their old value.
- R4: When a hitting fetch and a hitting data request meet in one cycle, the fetch uses the array and the data acknowledge stays low. The data access proceeds in the first cycle the array is free.
- R5: A request hits when (address AND WIN_MASK) == WIN_BASE. The word used is selected by address bits [IDX_W+1:2]. Addresses one word below or above the window are forwarded.
- R6: A request that misses the window drives the matching downstream request with the same address, write enable, byte selects and write data. The downstream acknowledge and read data return on that side in the same cycle.
- R7: A local acknowledge and a forwarded acknowledge never share a cycle on one side. A missing request that arrives while a local answer is being returned is held back one cycle.
- R8: With READ_ONLY = 1, a hitting store is acknowledged but does not change contents. A load of word index i returns 32'hC0DE0000 | i.
- R9: After reset neither acknowledge is asserted until a request arrives. Reset does not clear or alter the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_req | input | 1 | Fetch request from core |
| if_addr | input | 32 | Fetch physical address |
| if_ack | output | 1 | Fetch acknowledge |
| if_rdata | output | 32 | Fetched word |
| d_req | input | 1 | Data request from core, held until acknowledged |
| d_we | input | 1 | Data write enable |
| d_sel | input | 4 | Data byte selects |
| d_addr | input | 32 | Data physical address |
| d_wdata | input | 32 | Store data |
| d_ack | output | 1 | Data acknowledge |
| d_rdata | output | 32 | Load data |
| ic_req | output | 1 | Forwarded fetch request |
| ic_addr | output | 32 | Forwarded fetch address |
| ic_ack | input | 1 | Downstream fetch acknowledge |
| ic_rdata | input | 32 | Downstream fetch data |
| dc_req | output | 1 | Forwarded data request |
| dc_we | output | 1 | Forwarded write enable |
| dc_sel | output | 4 | Forwarded byte selects |
| dc_addr | output | 32 | Forwarded data address |
| dc_wdata | output | 32 | Forwarded store data |
| dc_ack | input | 1 | Downstream data acknowledge |
| dc_rdata | input | 32 | Downstream data read word |

## Verification
The bench targets the cycle where a fetch and a data access both hit. A design with the priority reversed, or with no stall, would acknowledge the store early or corrupt the fetched word. It also targets the cycle right after a local fetch answer, when a missing fetch arrives. A design without the hold-back would drive two answers at once or return the wrong word. Partial byte-select stores, the last word of the window and the words just outside it expose a wrong merge or a wrong decode. A ROM store followed by a reload, and a reset between a store and a load, show whether contents are touched when they must not be.

// File: rtl/spad_pkg.sv
package spad_pkg;

  localparam int WORD_W = 32;
  localparam int SEL_W  = WORD_W / 8;

  // Window decode: address belongs to the scratchpad
  function automatic logic in_window(input logic [31:0] addr,
                                     input logic [31:0] base,
                                     input logic [31:0] mask);
    return (addr & mask) == base;
  endfunction

  // Fixed content of the read-only variant, derived from the word index
  function automatic logic [WORD_W-1:0] rom_word(input logic [15:0] idx);
    return {16'hC0DE, idx};
  endfunction

endpackage

// File: rtl/spad_window.sv
module spad_window #(
  parameter logic [31:0] WIN_BASE = 32'h0001_0000,
  parameter logic [31:0] WIN_MASK = 32'hFFFF_FC00
) (
  input  logic [31:0] addr,
  output logic        hit
);
  import spad_pkg::*;

  always_comb hit = in_window(addr, WIN_BASE, WIN_MASK);

endmodule

// File: rtl/spad_arbiter.sv
module spad_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_hit_req,
  input  logic data_hit_req,
  input  logic data_we,
  output logic fetch_go,
  output logic ld_issue,
  output logic st_go,
  output logic if_pend,
  output logic ld_pend
);

  logic array_free;

  // The fetch side always owns the array when it hits
  always_comb begin
    fetch_go   = fetch_hit_req;
    array_free = !fetch_go && !ld_pend;
    ld_issue   = data_hit_req && !data_we && array_free;
    st_go      = data_hit_req &&  data_we && array_free;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      if_pend <= 1'b0;
      ld_pend <= 1'b0;
    end else begin
      if_pend <= fetch_go;
      ld_pend <= ld_issue;
    end
  end

endmodule

// File: rtl/spad_array.sv
module spad_array #(
  parameter int DEPTH     = 256,
  parameter bit READ_ONLY = 1'b0,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rd_en,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              idx,
  input  logic [spad_pkg::WORD_W-1:0]   wdata,
  input  logic [spad_pkg::SEL_W-1:0]    sel,
  output logic [spad_pkg::WORD_W-1:0]   rdata_q
);
  import spad_pkg::*;

  generate
    if (READ_ONLY) begin : g_rom
      logic [15:0] idx_ext;
      always_comb idx_ext = 16'(idx);
      always_ff @(posedge clk) begin
        if (rd_en) rdata_q <= rom_word(idx_ext);
      end
      logic unused_wr;
      always_comb unused_wr = wr_en ^ (^wdata) ^ (^sel);
    end else begin : g_ram
      logic [WORD_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (wr_en) begin
          for (int b = 0; b < SEL_W; b++) begin
            if (sel[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
          end
        end
        if (rd_en) rdata_q <= mem[idx];
      end
    end
  endgenerate

endmodule

// File: rtl/spad_shared.sv
module spad_shared #(
  parameter int          DEPTH     = 256,
  parameter logic [31:0] WIN_BASE  = 32'h0001_0000,
  parameter logic [31:0] WIN_MASK  = 32'hFFFF_FC00,
  parameter bit          READ_ONLY = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        if_req,
  input  logic [31:0] if_addr,
  output logic        if_ack,
  output logic [31:0] if_rdata,
  input  logic        d_req,
  input  logic        d_we,
  input  logic [3:0]  d_sel,
  input  logic [31:0] d_addr,
  input  logic [31:0] d_wdata,
  output logic        d_ack,
  output logic [31:0] d_rdata,
  output logic        ic_req,
  output logic [31:0] ic_addr,
  input  logic        ic_ack,
  input  logic [31:0] ic_rdata,
  output logic        dc_req,
  output logic        dc_we,
  output logic [3:0]  dc_sel,
  output logic [31:0] dc_addr,
  output logic [31:0] dc_wdata,
  input  logic        dc_ack,
  input  logic [31:0] dc_rdata
);
  localparam int IDX_W = $clog2(DEPTH);

  // Named internal events, also observed by the checker
  logic fetch_hit, data_hit;
  logic fetch_go, ld_issue, st_go;
  logic if_pend, ld_pend;
  logic [IDX_W-1:0] arr_idx;
  logic [31:0] arr_q;

  spad_window #(.WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK)) u_win_if (
    .addr(if_addr), .hit(fetch_hit)
  );

  spad_window #(.WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK)) u_win_d (
    .addr(d_addr), .hit(data_hit)
  );

  spad_arbiter u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_hit_req(if_req && fetch_hit),
    .data_hit_req (d_req && data_hit),
    .data_we      (d_we),
    .fetch_go     (fetch_go),
    .ld_issue     (ld_issue),
    .st_go        (st_go),
    .if_pend      (if_pend),
    .ld_pend      (ld_pend)
  );

  always_comb arr_idx = fetch_go ? if_addr[IDX_W+1:2] : d_addr[IDX_W+1:2];

  spad_array #(.DEPTH(DEPTH), .READ_ONLY(READ_ONLY)) u_arr (
    .clk    (clk),
    .rd_en  (fetch_go || ld_issue),
    .wr_en  (st_go),
    .idx    (arr_idx),
    .wdata  (d_wdata),
    .sel    (d_sel),
    .rdata_q(arr_q)
  );

  // Fetch side: forwarding is held off while a local answer is returned
  always_comb begin
    ic_req   = if_req && !fetch_hit && !if_pend;
    ic_addr  = if_addr;
    if_ack   = if_pend || (ic_req && ic_ack);
    if_rdata = if_pend ? arr_q : ic_rdata;
  end

  // Data side
  always_comb begin
    dc_req   = d_req && !data_hit && !ld_pend;
    dc_we    = d_we;
    dc_sel   = d_sel;
    dc_addr  = d_addr;
    dc_wdata = d_wdata;
    d_ack    = ld_pend || st_go || (dc_req && dc_ack);
    d_rdata  = ld_pend ? arr_q : dc_rdata;
  end

endmodule

// File: rtl/spad_shared_chk.sv
module spad_shared_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        if_req,
  input logic [31:0] if_addr,
  input logic        if_ack,
  input logic        d_req,
  input logic        d_we,
  input logic        d_ack,
  input logic        ic_req,
  input logic [31:0] ic_addr,
  input logic        dc_req,
  input logic        fetch_hit,
  input logic        data_hit,
  input logic        ld_issue,
  input logic        if_pend,
  input logic        ld_pend
);

  // R1
  fetch_ack_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req && fetch_hit) |=> if_ack);

  // R2
  load_ack_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_issue |=> (d_ack && !ld_issue));

  // R3
  store_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && data_hit && d_we && !(if_req && fetch_hit) && !ld_pend) |-> d_ack);

  // R4
  fetch_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req && fetch_hit && d_req && data_hit && !ld_pend) |-> !d_ack);

  // R6
  fetch_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req && !fetch_hit && !if_pend) |-> (ic_req && ic_addr == if_addr));

  // R7
  fetch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_pend |-> !ic_req);

  // R7
  data_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pend |-> !dc_req);

  // R9
  fetch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_req && !$past(if_req)) |-> !if_ack);

  // R9
  data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!d_req && !$past(d_req)) |-> !d_ack);

endmodule

bind spad_shared spad_shared_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .if_req   (if_req),
  .if_addr  (if_addr),
  .if_ack   (if_ack),
  .d_req    (d_req),
  .d_we     (d_we),
  .d_ack    (d_ack),
  .ic_req   (ic_req),
  .ic_addr  (ic_addr),
  .dc_req   (dc_req),
  .fetch_hit(fetch_hit),
  .data_hit (data_hit),
  .ld_issue (ld_issue),
  .if_pend  (if_pend),
  .ld_pend  (ld_pend)
);

// File: tb/tb_spad_shared.sv
module tb_spad_shared;

  localparam logic [31:0] B = 32'h0001_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        if_req, d_req, d_we;
  logic [31:0] if_addr, d_addr, d_wdata;
  logic [3:0]  d_sel;

  logic        if_ack, d_ack, ic_req, dc_req, dc_we, ic_ack, dc_ack;
  logic [31:0] if_rdata, d_rdata, ic_addr, dc_addr, dc_wdata, ic_rdata, dc_rdata;
  logic [3:0]  dc_sel;

  logic        r_if_ack, r_d_ack, r_ic_req, r_dc_req, r_dc_we;
  logic [31:0] r_if_rdata, r_d_rdata, r_ic_addr, r_dc_addr, r_dc_wdata;
  logic [3:0]  r_dc_sel;

  // Downstream models: answer in the cycle requested
  assign ic_ack   = ic_req;
  assign ic_rdata = 32'hF000_0000 ^ ic_addr;
  assign dc_ack   = dc_req;
  assign dc_rdata = 32'hD000_0000 ^ dc_addr;

  spad_shared dut (
    .clk(clk), .rst_n(rst_n),
    .if_req(if_req), .if_addr(if_addr), .if_ack(if_ack), .if_rdata(if_rdata),
    .d_req(d_req), .d_we(d_we), .d_sel(d_sel), .d_addr(d_addr), .d_wdata(d_wdata),
    .d_ack(d_ack), .d_rdata(d_rdata),
    .ic_req(ic_req), .ic_addr(ic_addr), .ic_ack(ic_ack), .ic_rdata(ic_rdata),
    .dc_req(dc_req), .dc_we(dc_we), .dc_sel(dc_sel), .dc_addr(dc_addr),
    .dc_wdata(dc_wdata), .dc_ack(dc_ack), .dc_rdata(dc_rdata)
  );

  spad_shared #(.READ_ONLY(1'b1)) rom_dut (
    .clk(clk), .rst_n(rst_n),
    .if_req(if_req), .if_addr(if_addr), .if_ack(r_if_ack), .if_rdata(r_if_rdata),
    .d_req(d_req), .d_we(d_we), .d_sel(d_sel), .d_addr(d_addr), .d_wdata(d_wdata),
    .d_ack(r_d_ack), .d_rdata(r_d_rdata),
    .ic_req(r_ic_req), .ic_addr(r_ic_addr), .ic_ack(r_ic_req),
    .ic_rdata(32'hF000_0000 ^ r_ic_addr),
    .dc_req(r_dc_req), .dc_we(r_dc_we), .dc_sel(r_dc_sel), .dc_addr(r_dc_addr),
    .dc_wdata(r_dc_wdata), .dc_ack(r_dc_req), .dc_rdata(32'hD000_0000 ^ r_dc_addr)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic store(input logic [31:0] a, input logic [3:0] s, input logic [31:0] w,
                       input string tag);
    @(negedge clk);
    d_req = 1'b1; d_we = 1'b1; d_addr = a; d_sel = s; d_wdata = w;
    #1 check(tag, {31'd0, d_ack}, 32'd1);
    @(negedge clk);
    d_req = 1'b0; d_we = 1'b0;
  endtask

  task automatic load(input logic [31:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    d_req = 1'b1; d_we = 1'b0; d_addr = a; d_sel = 4'hF;
    #1 check({tag, " ack low in issue cycle"}, {31'd0, d_ack}, 32'd0);
    @(negedge clk);
    #1 check({tag, " ack"}, {31'd0, d_ack}, 32'd1);
    check({tag, " data"}, d_rdata, exp);
    d_req = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic [3:0]  sel;
    logic [9:0]  off;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  // R3 / R2 / R5: byte-merge stores and loads inside the window
  localparam vec_t VEC [12] = '{
    '{1'b1, 4'hF, 10'h000, 32'h1122_3344, 32'h0},
    '{1'b0, 4'hF, 10'h000, 32'h0,         32'h1122_3344},
    '{1'b1, 4'h1, 10'h000, 32'hAAAA_AAAA, 32'h0},
    '{1'b1, 4'h8, 10'h000, 32'h5555_5555, 32'h0},
    '{1'b0, 4'hF, 10'h000, 32'h0,         32'h5522_33AA},
    '{1'b1, 4'hF, 10'h3FC, 32'hDEAD_BEEF, 32'h0},
    '{1'b1, 4'h6, 10'h3FC, 32'h00CA_FE00, 32'h0},
    '{1'b0, 4'hF, 10'h3FC, 32'h0,         32'hDECA_FEEF},
    '{1'b1, 4'hF, 10'h004, 32'h0BAD_F00D, 32'h0},
    '{1'b1, 4'hF, 10'h008, 32'h1357_9BDF, 32'h0},
    '{1'b0, 4'hF, 10'h004, 32'h0,         32'h0BAD_F00D},
    '{1'b0, 4'hF, 10'h008, 32'h0,         32'h1357_9BDF}
  };

  initial begin
    rst_n = 1'b0; if_req = 1'b0; d_req = 1'b0; d_we = 1'b0;
    if_addr = '0; d_addr = '0; d_wdata = '0; d_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R9 reset fetch ack", {31'd0, if_ack}, 32'd0);
    check("R9 reset data ack", {31'd0, d_ack}, 32'd0);

    for (int i = 0; i < 12; i++) begin
      if (VEC[i].we)
        store(B + 32'(VEC[i].off), VEC[i].sel, VEC[i].wd, "R3 table store ack");
      else
        load(B + 32'(VEC[i].off), VEC[i].exp, "R2 table load");
    end

    // R1: back-to-back fetches, one word per clock
    @(negedge clk); if_req = 1'b1; if_addr = B;
    @(negedge clk); if_addr = B + 4;
    #1 check("R1 fetch0 ack", {31'd0, if_ack}, 32'd1);
    check("R1 fetch0 data", if_rdata, 32'h5522_33AA);
    @(negedge clk); if_addr = B + 8;
    #1 check("R1 fetch1 data", if_rdata, 32'h0BAD_F00D);
    @(negedge clk); if_req = 1'b0;
    #1 check("R1 fetch2 ack", {31'd0, if_ack}, 32'd1);
    check("R1 fetch2 data", if_rdata, 32'h1357_9BDF);
    @(negedge clk);
    #1 check("R9 fetch ack idle", {31'd0, if_ack}, 32'd0);

    // R4: store collides with fetch
    @(negedge clk);
    if_req = 1'b1; if_addr = B;
    d_req = 1'b1; d_we = 1'b1; d_addr = B + 12; d_sel = 4'hF; d_wdata = 32'h7777_8888;
    #1 check("R4 store stalled", {31'd0, d_ack}, 32'd0);
    @(negedge clk); if_req = 1'b0;
    #1 check("R4 fetch served", if_rdata, 32'h5522_33AA);
    check("R4 store acked when free", {31'd0, d_ack}, 32'd1);
    @(negedge clk); d_req = 1'b0; d_we = 1'b0;

    // R4: load collides with fetch
    @(negedge clk);
    if_req = 1'b1; if_addr = B + 4;
    d_req = 1'b1; d_addr = B + 12;
    #1 check("R4 load stalled", {31'd0, d_ack}, 32'd0);
    @(negedge clk); if_req = 1'b0;
    #1 check("R4 fetch word1", if_rdata, 32'h0BAD_F00D);
    check("R4 load still waiting", {31'd0, d_ack}, 32'd0);
    @(negedge clk);
    #1 check("R4 load ack", {31'd0, d_ack}, 32'd1);
    check("R4 load data", d_rdata, 32'h7777_8888);
    d_req = 1'b0;

    // R6: forwarded data load / store and fetch
    @(negedge clk); d_req = 1'b1; d_addr = 32'h0004_0010;
    #1 check("R6 load fwd req", {31'd0, dc_req}, 32'd1);
    check("R6 load fwd data", d_rdata, 32'hD004_0010);
    check("R6 load fwd ack", {31'd0, d_ack}, 32'd1);
    d_req = 1'b0;
    @(negedge clk);
    d_req = 1'b1; d_we = 1'b1; d_addr = 32'h0004_0020; d_sel = 4'h5; d_wdata = 32'h1234_5678;
    #1 check("R6 store fwd we", {27'd0, dc_we, dc_sel}, 32'h15);
    check("R6 store fwd data", dc_wdata, 32'h1234_5678);
    check("R6 store fwd addr", dc_addr, 32'h0004_0020);
    d_req = 1'b0; d_we = 1'b0;

    // R5: neighbours of the window are forwarded
    @(negedge clk); d_req = 1'b1; d_addr = B + 32'h400;
    #1 check("R5 above window", d_rdata, 32'hD001_0400);
    @(negedge clk); d_addr = B - 4;
    #1 check("R5 below window", d_rdata, 32'hD000_FFFC);
    d_req = 1'b0;

    // R7: miss right after a local fetch answer waits one cycle
    @(negedge clk); if_req = 1'b1; if_addr = B;
    @(negedge clk); if_addr = 32'h0008_0000;
    #1 check("R7 no fwd during local ack", {31'd0, ic_req}, 32'd0);
    check("R7 local word", if_rdata, 32'h5522_33AA);
    @(negedge clk);
    #1 check("R7 fwd next cycle", {31'd0, ic_req}, 32'd1);
    check("R7 fwd data", if_rdata, 32'hF008_0000);
    if_req = 1'b0;

    // R8: read-only variant
    @(negedge clk); d_req = 1'b1; d_we = 1'b0; d_addr = B + 32'h14;
    @(negedge clk);
    #1 check("R8 rom load", r_d_rdata, 32'hC0DE_0005);
    d_req = 1'b0;
    @(negedge clk);
    d_req = 1'b1; d_we = 1'b1; d_sel = 4'hF; d_wdata = 32'hFFFF_FFFF;
    #1 check("R8 rom store ack", {31'd0, r_d_ack}, 32'd1);
    @(negedge clk); d_req = 1'b0; d_we = 1'b0;
    @(negedge clk); d_req = 1'b1; d_addr = B + 32'h14;
    @(negedge clk);
    #1 check("R8 rom unchanged", r_d_rdata, 32'hC0DE_0005);
    d_req = 1'b0;

    // R9: reset keeps contents
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    #1 check("R9 acks low in reset", {30'd0, if_ack, d_ack}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R9 acks low after reset", {30'd0, if_ack, d_ack}, 32'd0);
    load(B, 32'h5522_33AA, "R9 contents kept");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule